// File: doc/BRIEF.md
# Programmable-Height Character Row Scanner

This block tracks the vertical position of an on-screen character overlay. It counts horizontal sync pulses after each vertical sync, waits out a programmable top margin, and then names, for every scan line, which memory row of character codes is on screen and which of the sixteen font lines belongs on that line. A downstream fetch stage uses the two indices to address character memory and the font store. The horizontal dot timing is not part of this block.

The character cell can be stretched to any height from 16 to 63 scan lines. The font line index is spread evenly across the programmed height. Any memory row can be flagged as double height. Such a row spans two screen rows, and every memory row after it moves down by one screen row. The overlay ends when the last memory row is done or when ten screen rows have been used, whichever comes first.

Top module: `osd_row_scanner`

## Requirements
- R1: After reset, and whenever `disp_active` is 0, `mem_row` and `font_line` both read 0.
- R2: With `vsync_pol` = 0 the falling edge of `vsync_in` is the active edge, and with `vsync_pol` = 1 the rising edge is. The opposite edge has no effect.
- R3: Call D the value of `vdelay`. `disp_active` first goes high with row 0 and line 0 on the (4·D+2)-th rising edge of `hsync_in` after the active vertical edge, so 4·D+1 whole lines are skipped. Outputs change in the clock cycle after the cycle in which the new `hsync_in` level is first sampled.
- R4: Call Heff the effective height. A row whose bit is clear in `dbl_rows` occupies Heff consecutive scan lines, and then `mem_row` increases by one.
- R5: In such a row, scan line l (counting from 0 to Heff-1) shows font line floor(l·16/Heff).
- R6: When bit n of `dbl_rows` is set, memory row n occupies 2·Heff scan lines. Its scan line l shows font line floor(floor(l/2)·16/Heff), and all later rows start correspondingly later.
- R7: The display turns off after memory row 9 completes, or once 10 screen rows have been used (a double row counts as two), whichever comes first. A double row that starts on the tenth screen row shows only its first half. The display stays off until the next active vertical edge.
- R8: An active vertical edge clears the display in the next cycle, even in the middle of a frame, and restarts the delay count.
- R9: A `char_height` below 16 behaves as 16. Otherwise Heff equals `char_height`.
- R10: `hsync_in` is active high. Each rising edge advances the count once, however long the pulse lasts, and the outputs hold between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active level set by `vsync_pol` |
| vsync_pol | input | 1 | 0: vertical sync active low; 1: active high |
| char_height | input | 6 | Scan lines per character row (16..63) |
| vdelay | input | 8 | Top margin in steps of four lines |
| dbl_rows | input | 10 | Bit n set makes memory row n double height |
| disp_active | output | 1 | High while a character row is on the current line |
| mem_row | output | 4 | Memory row index shown on the current line |
| font_line | output | 4 | Font line index (0..15) for the current line |

## Verification
The scanner is driven through whole frames with different combinations of delay, height and double-row pattern. The minimum height with no double rows checks the basic row stepping and the identity font mapping. A height of 23 with scattered double rows checks the uneven font spreading and the early stop at ten screen rows. A height of 63 with only the last row doubled checks the truncated final half under the other sync polarity. A height below 16 with every row doubled checks the clamp. The vertical pulse is kept active across the first few lines so that detecting the wrong edge gives a shifted count. A restart in mid-frame and a stretched horizontal pulse check the edge handling.

// File: rtl/osd_rowscan_pkg.sv
package osd_rowscan_pkg;

  localparam int HGT_W      = 6;
  localparam int DLY_W      = 8;
  localparam int FONT_LINES = 16;
  localparam int FL_W       = $clog2(FONT_LINES);
  localparam int MIN_HEIGHT = 16;
  localparam int DCNT_W     = DLY_W + 2;
  localparam int LIR_W      = HGT_W + 1;

  // Heights below the font size are clamped up to it.
  function automatic logic [HGT_W-1:0] eff_height(input logic [HGT_W-1:0] h);
    return (h < HGT_W'(MIN_HEIGHT)) ? HGT_W'(MIN_HEIGHT) : h;
  endfunction

  // Index of the last skipped line: four lines per step plus one.
  function automatic logic [DCNT_W-1:0] delay_target(input logic [DLY_W-1:0] d);
    return {d, 2'b00} + DCNT_W'(1);
  endfunction

  // Spread the font over the row height; double rows halve the line first.
  function automatic logic [FL_W-1:0] font_line_of(input logic [LIR_W-1:0] lir,
                                                    input logic             dbl,
                                                    input logic [HGT_W-1:0] h);
    logic [LIR_W-1:0] l;
    logic [15:0]      num;
    logic [15:0]      quo;
    l   = dbl ? (lir >> 1) : lir;
    num = 16'(l) * 16'(FONT_LINES);
    quo = num / 16'(eff_height(h));
    return quo[FL_W-1:0];
  endfunction

endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic active_high,
  output logic edge_o
);
  logic lvl;
  logic lvl_q;

  assign lvl    = ~(sig_in ^ active_high);
  assign edge_o = lvl & ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl;
  end

  // R10: a single transition yields a single event
  p_single_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);

endmodule

// File: rtl/osd_vdelay_cnt.sv
module osd_vdelay_cnt
  import osd_rowscan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vs_edge,
  input  logic             hs_edge,
  input  logic [DLY_W-1:0] vdelay,
  output logic             start_o
);
  logic              armed;
  logic [DCNT_W-1:0] cnt;
  logic [DCNT_W-1:0] target;
  logic              delay_done;

  assign target     = delay_target(vdelay);
  assign delay_done = (cnt >= target);
  assign start_o    = armed & hs_edge & ~vs_edge & delay_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (vs_edge) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (hs_edge && armed) begin
      if (delay_done) armed <= 1'b0;
      else            cnt   <= cnt + DCNT_W'(1);
    end
  end

  // R3: every frame restarts the margin count from zero
  p_arm_on_vs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge |=> (armed && cnt == '0));

  // R3: display start fires at most once per frame
  p_one_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !armed);

endmodule

// File: rtl/osd_row_seq.sv
module osd_row_seq
  import osd_rowscan_pkg::*;
#(
  parameter int N_ROWS   = 10,
  parameter int N_SCREEN = 10,
  parameter int ROW_W    = $clog2(N_ROWS),
  parameter int SCR_W    = $clog2(N_SCREEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vs_edge,
  input  logic              hs_edge,
  input  logic              start_i,
  input  logic [HGT_W-1:0]  char_height,
  input  logic [N_ROWS-1:0] dbl_rows,
  output logic              active_o,
  output logic [ROW_W-1:0]  mem_row_o,
  output logic [FL_W-1:0]   font_line_o
);
  logic              active;
  logic [ROW_W-1:0]  mem;
  logic [SCR_W-1:0]  scr;
  logic [HGT_W-1:0]  sub;
  logic              half;

  logic [HGT_W-1:0]  heff;
  logic              row_dbl;
  logic              last_line;
  logic              line_step;
  logic              row_end;
  logic [SCR_W-1:0]  scr_next;
  logic              screen_full;
  logic              last_mem_done;
  logic              frame_done;
  logic [LIR_W-1:0]  lir;

  assign heff          = eff_height(char_height);
  assign row_dbl       = dbl_rows[mem];
  assign last_line     = (sub >= heff - HGT_W'(1));
  assign line_step     = hs_edge & active & ~vs_edge;
  assign row_end       = line_step & last_line;
  assign scr_next      = scr + SCR_W'(1);
  assign screen_full   = (scr_next == SCR_W'(N_SCREEN));
  assign last_mem_done = ~(row_dbl & ~half) & (mem == ROW_W'(N_ROWS - 1));
  assign frame_done    = row_end & (screen_full | last_mem_done);
  assign lir           = half ? (LIR_W'(heff) + LIR_W'(sub)) : LIR_W'(sub);

  assign active_o    = active;
  assign mem_row_o   = mem;
  assign font_line_o = active ? font_line_of(lir, row_dbl, char_height) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      mem    <= '0;
      scr    <= '0;
      sub    <= '0;
      half   <= 1'b0;
    end else if (vs_edge || start_i) begin
      active <= start_i & ~vs_edge;
      mem    <= '0;
      scr    <= '0;
      sub    <= '0;
      half   <= 1'b0;
    end else if (line_step) begin
      if (!last_line) begin
        sub <= sub + HGT_W'(1);
      end else if (frame_done) begin
        active <= 1'b0;
        mem    <= '0;
        scr    <= '0;
        sub    <= '0;
        half   <= 1'b0;
      end else begin
        sub <= '0;
        scr <= scr_next;
        if (row_dbl && !half) begin
          half <= 1'b1;
        end else begin
          half <= 1'b0;
          mem  <= mem + ROW_W'(1);
        end
      end
    end
  end

  // R8: a vertical edge always blanks the next cycle
  p_vs_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge |=> !active_o);

  // R3: the first displayed line is row 0, font line 0
  p_start_row0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !vs_edge) |=> (active_o && mem_row_o == '0 && font_line_o == '0));

  // R10: nothing moves between sync events
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_edge && !vs_edge) |=> ($stable(active) && $stable(mem) && $stable(sub) && $stable(half)));

  // R7: screen row and memory row counts stay inside the frame
  p_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scr < SCR_W'(N_SCREEN)) && (mem < ROW_W'(N_ROWS)));

endmodule

// File: rtl/osd_row_scanner.sv
module osd_row_scanner
  import osd_rowscan_pkg::*;
#(
  parameter int N_ROWS        = 10,
  parameter int N_SCREEN_ROWS = 10,
  localparam int ROW_W        = $clog2(N_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              vsync_pol,
  input  logic [HGT_W-1:0]  char_height,
  input  logic [DLY_W-1:0]  vdelay,
  input  logic [N_ROWS-1:0] dbl_rows,
  output logic              disp_active,
  output logic [ROW_W-1:0]  mem_row,
  output logic [FL_W-1:0]   font_line
);
  logic hs_edge;
  logic vs_edge;
  logic disp_start;

  osd_sync_edge u_hs_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .sig_in      (hsync_in),
    .active_high (1'b1),
    .edge_o      (hs_edge)
  );

  osd_sync_edge u_vs_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .sig_in      (vsync_in),
    .active_high (vsync_pol),
    .edge_o      (vs_edge)
  );

  osd_vdelay_cnt u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .vs_edge (vs_edge),
    .hs_edge (hs_edge),
    .vdelay  (vdelay),
    .start_o (disp_start)
  );

  osd_row_seq #(
    .N_ROWS   (N_ROWS),
    .N_SCREEN (N_SCREEN_ROWS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .vs_edge     (vs_edge),
    .hs_edge     (hs_edge),
    .start_i     (disp_start),
    .char_height (char_height),
    .dbl_rows    (dbl_rows),
    .active_o    (disp_active),
    .mem_row_o   (mem_row),
    .font_line_o (font_line)
  );

  // R1: idle output names row 0
  p_idle_row0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_active |-> (mem_row == '0 && font_line == '0));

  // R4: memory rows are visited in order, one step at a time
  p_row_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_active && $past(disp_active) && mem_row != $past(mem_row))
      |-> (mem_row == ROW_W'($past(mem_row) + 1'b1)));

endmodule

// File: tb/osd_row_scanner_bench.sv
`timescale 1ns/1ps
module osd_row_scanner_bench;
  localparam int N_ROWS = 10;
  localparam int N_SCR  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsync_in = 1'b0;
  logic        vsync_in = 1'b1;
  logic        vsync_pol = 1'b0;
  logic [5:0]  char_height = 6'd16;
  logic [7:0]  vdelay = 8'd4;
  logic [9:0]  dbl_rows = '0;
  wire         disp_active;
  wire  [3:0]  mem_row;
  wire  [3:0]  font_line;

  typedef struct {
    logic       act;
    logic [3:0] row;
    logic [3:0] line;
    string      req;
  } exp_t;

  exp_t  sb_q[$];
  event  sample_ev;
  int    n_checks = 0;
  int    n_fail = 0;
  int    line_k = 0;
  bit    run_done = 1'b0;
  string frame_pfx = "";

  always #2.5 clk = ~clk;

  osd_row_scanner u_osd_row_scanner (
    .clk (clk), .rst_n (rst_n), .hsync_in (hsync_in), .vsync_in (vsync_in),
    .vsync_pol (vsync_pol), .char_height (char_height), .vdelay (vdelay),
    .dbl_rows (dbl_rows), .disp_active (disp_active), .mem_row (mem_row),
    .font_line (font_line)
  );

  // Reference: walk the frame by spans of scan lines
  function automatic exp_t model(int k, int d, int h, logic [9:0] dbl);
    exp_t e;
    int heff, rem, scr, rows, span;
    e.act = 1'b0; e.row = '0; e.line = '0;
    heff = (h < 16) ? 16 : h;
    if (k <= 4 * d + 1) begin e.req = "R3"; return e; end
    rem = k - (4 * d + 2);
    scr = 0;
    for (int m = 0; m < N_ROWS; m++) begin
      if (scr >= N_SCR) break;
      rows = dbl[m] ? 2 : 1;
      if (scr + rows > N_SCR) rows = 1;
      span = rows * heff;
      if (rem < span) begin
        e.act = 1'b1;
        e.row = 4'(m);
        e.line = dbl[m] ? 4'(((rem / 2) * 16) / heff) : 4'((rem * 16) / heff);
        e.req = (h < 16) ? "R9" : (dbl[m] ? "R6" : "R4/R5");
        return e;
      end
      rem -= span;
      scr += rows;
    end
    e.req = "R7";
    return e;
  endfunction

  task automatic push(exp_t e);
    e.req = {frame_pfx, e.req};
    sb_q.push_back(e);
    -> sample_ev;
  endtask

  // Monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (disp_active !== e.act || mem_row !== e.row || font_line !== e.line) begin
          n_fail++;
          $display("FAIL %s: act/row/line got %0b/%0d/%0d exp %0b/%0d/%0d",
                   e.req, disp_active, mem_row, font_line, e.act, e.row, e.line);
        end
      end
    end
  end

  task automatic hline(int hold);
    exp_t e;
    @(negedge clk) hsync_in = 1'b1;
    @(negedge clk);
    line_k++;
    e = model(line_k, vdelay, char_height, dbl_rows);
    push(e);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      e.req = "R10";
      push(e);
    end
    hsync_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic lines(int n);
    for (int i = 0; i < n; i++) hline(0);
  endtask

  task automatic vs_assert(string tag);
    exp_t e;
    @(negedge clk) vsync_in = vsync_pol;
    @(negedge clk);
    line_k = 0;
    e = model(0, vdelay, char_height, dbl_rows);
    e.req = tag;
    push(e);
  endtask

  task automatic vs_release();
    @(negedge clk) vsync_in = ~vsync_pol;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!run_done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, got done=0 exp done=1");
      finish_run();
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    e.act = 1'b0; e.row = '0; e.line = '0; e.req = "R1 reset";
    push(e);
    rst_n = 1'b1;
    @(negedge clk);

    // Frame 1: minimum height, no doubles, negative vertical sync (R2, R4, R5)
    vdelay = 8'd1; char_height = 6'd16; dbl_rows = '0;
    vs_assert("R2 neg");
    lines(2);
    vs_release();
    lines(4 * 1 + 160 + 2);

    // Frame 2: odd height, scattered doubles, stop at ten screen rows (R6, R7)
    vdelay = 8'd2; char_height = 6'd23; dbl_rows = 10'b00_0010_0101;
    vs_assert("R2 neg");
    lines(2);
    vs_release();
    lines(9 + 230 + 3);

    // Frame 3: positive vertical sync, max height, last row doubled (R2, R7, R10)
    @(negedge clk) begin vsync_in = 1'b0; vsync_pol = 1'b1; end
    vdelay = 8'd3; char_height = 6'd63; dbl_rows = 10'b10_0000_0000;
    frame_pfx = "R2 ";
    vs_assert("R2 pos");
    lines(3);
    vs_release();
    lines(40);
    hline(6);
    lines(13 + 630 - 44 + 3);
    frame_pfx = "";

    // Frame 4: height below the font clamps to 16, all rows doubled (R9)
    @(negedge clk) begin vsync_in = 1'b1; vsync_pol = 1'b0; end
    vdelay = 8'd1; char_height = 6'd5; dbl_rows = 10'b11_1111_1111;
    vs_assert("R2 neg");
    lines(2);
    vs_release();
    lines(6 + 160 + 3);

    // Frame 5: restart in mid-frame (R8)
    vdelay = 8'd1; char_height = 6'd16; dbl_rows = '0;
    vs_assert("R2 neg");
    vs_release();
    lines(40);
    vs_assert("R8 restart");
    vs_release();
    lines(6 + 24);

    repeat (2) @(negedge clk);
    run_done = 1'b1;
    finish_run();
  end

endmodule